// File: doc/BRIEF.md
# Instruction Prefix and Size Attribute Decoder

This block is the first stage of an instruction front end. It receives instruction bytes one per accepted beat and absorbs the leading prefix bytes. At the opcode byte it produces one record: the effective operand size, the effective address size, the selected segment override, the lock and repeat attributes, the register-extension bits of a 64-bit extension prefix, the opcode byte, and whether that opcode followed the 0x0F escape byte. A one-cycle done pulse marks the record. The block then starts the next instruction from a clean state.

A processor mode selector gives the default sizes. The size-override prefixes toggle between the two sizes that are legal in the current mode. They do not force fixed values. The register-extension prefix exists only in 64-bit mode and only counts when it is the last prefix before the opcode. The number of legacy prefixes is bounded. Later stages (operand-form parsing, operand fetch, execution) take the record and the bytes that follow it.

Top module: `insn_prefix_decoder`

## Requirements
- R1: After reset `done_o` is 0 and `byte_ready_o` is 1. Every record output is 0.
- R2: `done_o` is high for exactly the one cycle after the opcode byte is accepted. All record outputs are loaded in that same cycle and hold their values until the next done pulse.
- R3: `byte_ready_o` is low in the cycle in which `done_o` is high, and high in every other cycle. A byte offered while ready is low is not consumed.
- R4: `mode_i` selects the default sizes: 0 is real mode (operand 2, address 2), 1 is 16-bit protected (2, 2), 2 is 32-bit protected (4, 4) and 3 is 64-bit (4, 8). Sizes on `op_bytes_o` and `addr_bytes_o` are given in bytes.
- R5: Each 0x66 byte toggles the operand size between 2 and 4. Each 0x67 byte toggles the address size: between 4 and 8 in mode 3, and between 2 and 4 in all other modes. An even number of the same override restores the default.
- R6: Segment overrides set `seg_o` as follows: 0x26 gives 1, 0x2E gives 2, 0x36 gives 3, 0x3E gives 4, 0x64 gives 5 and 0x65 gives 6. A value of 0 means no override. The last override wins.
- R7: 0xF0 sets `lock_o`. 0xF3 selects `rep_o` and 0xF2 selects `repne_o`. These two are mutually exclusive, and the later one replaces the earlier.
- R8: In mode 3 only, a byte 0x40 to 0x4F is the extension prefix. It sets `rex_o`, and its bits 3, 2, 1 and 0 drive `rex_w_o`, `rex_r_o`, `rex_x_o` and `rex_b_o`. When W is set the operand size is 8, whatever 0x66 did. A later extension byte replaces an earlier one. In other modes such a byte is a one-byte opcode.
- R9: An extension byte that is followed by a legacy prefix byte is discarded. In that case `rex_o` and all four extension bits are 0 in the record.
- R10: An opcode byte of 0x0F is not reported. The byte after it, whatever its value, is reported on `opcode_o` with `two_byte_o` = 1. Otherwise `two_byte_o` = 0.
- R11: At most 8 legacy prefix bytes are consumed. A ninth byte with a prefix value is treated as a non-prefix byte: as an extension byte in mode 3 if it has that form, otherwise as the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Processor mode: 0 real, 1 16-bit protected, 2 32-bit protected, 3 64-bit |
| byte_valid_i | input | 1 | An instruction byte is offered |
| byte_i | input | 8 | Offered instruction byte |
| byte_ready_o | output | 1 | The block can take a byte this cycle |
| done_o | output | 1 | One-cycle pulse: a new record is on the outputs |
| opcode_o | output | 8 | Opcode byte (the byte after 0x0F for escaped opcodes) |
| two_byte_o | output | 1 | Opcode followed the 0x0F escape |
| op_bytes_o | output | 4 | Effective operand size in bytes |
| addr_bytes_o | output | 4 | Effective address size in bytes |
| seg_o | output | 3 | Segment override code, 0 for none |
| lock_o | output | 1 | Lock attribute |
| rep_o | output | 1 | Repeat / repeat-while-equal attribute |
| repne_o | output | 1 | Repeat-while-not-equal attribute |
| rex_o | output | 1 | An extension prefix applies |
| rex_w_o | output | 1 | Extension W bit |
| rex_r_o | output | 1 | Extension of the operand-form reg field |
| rex_x_o | output | 1 | Extension of the scaled-index field |
| rex_b_o | output | 1 | Extension of the base / rm field |

## Verification
Internal state shows at the ports only through the next record. A toggle bit, a segment code, a stale extension byte or a wrong prefix count is therefore seen at the first done pulse after the bad byte. The escape flag and the prefix counter also change the timing: if one is wrong, the done pulse comes one byte early or late, and ready drops on the wrong cycle. The reference model predicts every output for every cycle. A wrong state is caught in the first cycle it reaches a port, and the byte sequences are built so that each piece of state is visible in a record soon after it is set.

// File: rtl/insn_pfx_pkg.sv
// Package: shared encodings for the instruction prefix decoder.
// Assumes: sizes are carried as byte counts in 4-bit fields.
package insn_pfx_pkg;

    localparam int SIZE_W = 4;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_PROT16 = 2'd1,
        MODE_PROT32 = 2'd2,
        MODE_LONG   = 2'd3
    } cpu_mode_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_sel_e;

    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_OPSZ  = 3'd1,
        PK_ADSZ  = 3'd2,
        PK_SEG   = 3'd3,
        PK_LOCK  = 3'd4,
        PK_REP   = 3'd5,
        PK_REPNE = 3'd6
    } pfx_kind_e;

    localparam logic [7:0] ESCAPE_BYTE = 8'h0F;

endpackage

// File: rtl/pfx_classify.sv
// Module: pfx_classify
// Purely combinational classification of one instruction byte: which
// legacy prefix it is (if any), the segment it selects, whether it is a
// 64-bit extension prefix and whether it is the two-byte escape.
// Assumes: mode_i is stable while the byte is presented.
module pfx_classify
    import insn_pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [1:0] mode_i,
    output pfx_kind_e  kind_o,
    output seg_sel_e   seg_o,
    output logic       is_ext_o,
    output logic       is_escape_o
);

    // Map the byte value to a legacy prefix kind and a segment code.
    always_comb begin
        kind_o = PK_NONE;
        seg_o  = SEG_NONE;
        case (byte_i)
            8'h66: kind_o = PK_OPSZ;
            8'h67: kind_o = PK_ADSZ;
            8'h26: begin kind_o = PK_SEG; seg_o = SEG_ES; end
            8'h2E: begin kind_o = PK_SEG; seg_o = SEG_CS; end
            8'h36: begin kind_o = PK_SEG; seg_o = SEG_SS; end
            8'h3E: begin kind_o = PK_SEG; seg_o = SEG_DS; end
            8'h64: begin kind_o = PK_SEG; seg_o = SEG_FS; end
            8'h65: begin kind_o = PK_SEG; seg_o = SEG_GS; end
            8'hF0: kind_o = PK_LOCK;
            8'hF3: kind_o = PK_REP;
            8'hF2: kind_o = PK_REPNE;
            default: ;
        endcase
    end

    // Extension prefix exists only in 64-bit mode.
    assign is_ext_o    = (mode_i == MODE_LONG) && (byte_i[7:4] == 4'h4);
    assign is_escape_o = (byte_i == ESCAPE_BYTE);

endmodule

// File: rtl/pfx_size_resolve.sv
// Module: pfx_size_resolve
// Combinational resolution of effective operand and address sizes from
// the mode defaults, the accumulated override toggles and the W bit.
// Assumes: toggles are parity flags (each override flips them).
module pfx_size_resolve
    import insn_pfx_pkg::*;
(
    input  logic [1:0]        mode_i,
    input  logic              op_tog_i,
    input  logic              ad_tog_i,
    input  logic              ext_w_i,
    output logic [SIZE_W-1:0] op_bytes_o,
    output logic [SIZE_W-1:0] addr_bytes_o
);

    logic narrow_mode;
    assign narrow_mode = (mode_i == MODE_REAL) || (mode_i == MODE_PROT16);

    // Operand size: W wins, otherwise the mode default flipped by 0x66.
    always_comb begin
        if (ext_w_i)
            op_bytes_o = SIZE_W'(8);
        else if (narrow_mode ^ op_tog_i)
            op_bytes_o = SIZE_W'(2);
        else
            op_bytes_o = SIZE_W'(4);
    end

    // Address size: each mode has its own pair, 0x67 picks the other one.
    always_comb begin
        case (mode_i)
            MODE_LONG:   addr_bytes_o = ad_tog_i ? SIZE_W'(4) : SIZE_W'(8);
            MODE_PROT32: addr_bytes_o = ad_tog_i ? SIZE_W'(2) : SIZE_W'(4);
            default:     addr_bytes_o = ad_tog_i ? SIZE_W'(4) : SIZE_W'(2);
        endcase
    end

endmodule

// File: rtl/insn_prefix_decoder.sv
// Module: insn_prefix_decoder (top)
// Byte-serial prefix front end. Consumes legacy prefixes (bounded count),
// an optional 64-bit extension prefix and an optional 0x0F escape, and on
// the opcode byte emits a registered record with a one-cycle done pulse.
// Ready is dropped in the done cycle; the next instruction starts after.
// Assumes: mode_i is constant from the first byte to the opcode byte.
module insn_prefix_decoder
    import insn_pfx_pkg::*;
#(
    parameter int MAX_PREFIXES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              byte_ready_o,
    output logic              done_o,
    output logic [7:0]        opcode_o,
    output logic              two_byte_o,
    output logic [SIZE_W-1:0] op_bytes_o,
    output logic [SIZE_W-1:0] addr_bytes_o,
    output logic [2:0]        seg_o,
    output logic              lock_o,
    output logic              rep_o,
    output logic              repne_o,
    output logic              rex_o,
    output logic              rex_w_o,
    output logic              rex_r_o,
    output logic              rex_x_o,
    output logic              rex_b_o
);

    localparam int CNT_W = $clog2(MAX_PREFIXES + 1);

    // Accumulated per-instruction state.
    logic [CNT_W-1:0] pfx_cnt_q;
    logic             op_tog_q, ad_tog_q, lock_q, rep_q, repne_q, esc_q;
    seg_sel_e         seg_q;
    logic             ext_q;
    logic [3:0]       ext_bits_q;

    // Classification and size resolution of the current byte / state.
    pfx_kind_e        kind;
    seg_sel_e         byte_seg;
    logic             is_ext, is_escape;
    logic [SIZE_W-1:0] op_sz, ad_sz;

    pfx_classify u_classify (
        .byte_i      (byte_i),
        .mode_i      (mode_i),
        .kind_o      (kind),
        .seg_o       (byte_seg),
        .is_ext_o    (is_ext),
        .is_escape_o (is_escape)
    );

    pfx_size_resolve u_size (
        .mode_i       (mode_i),
        .op_tog_i     (op_tog_q),
        .ad_tog_i     (ad_tog_q),
        .ext_w_i      (ext_q & ext_bits_q[3]),
        .op_bytes_o   (op_sz),
        .addr_bytes_o (ad_sz)
    );

    logic accept, take_pfx, finish;
    assign byte_ready_o = ~done_o;
    assign accept       = byte_valid_i & byte_ready_o;
    assign take_pfx     = (kind != PK_NONE) && (pfx_cnt_q < CNT_W'(MAX_PREFIXES));
    assign finish       = accept && (esc_q || (!take_pfx && !is_ext && !is_escape));

    // Per-instruction accumulation of prefix effects; cleared on finish.
    always_ff @(posedge clk) begin
        if (!rst_n || finish) begin
            pfx_cnt_q  <= '0;
            op_tog_q   <= 1'b0;
            ad_tog_q   <= 1'b0;
            lock_q     <= 1'b0;
            rep_q      <= 1'b0;
            repne_q    <= 1'b0;
            esc_q      <= 1'b0;
            seg_q      <= SEG_NONE;
            ext_q      <= 1'b0;
            ext_bits_q <= 4'h0;
        end else if (accept) begin
            if (take_pfx) begin
                pfx_cnt_q  <= pfx_cnt_q + CNT_W'(1);
                ext_q      <= 1'b0;
                ext_bits_q <= 4'h0;
                case (kind)
                    PK_OPSZ:  op_tog_q <= ~op_tog_q;
                    PK_ADSZ:  ad_tog_q <= ~ad_tog_q;
                    PK_SEG:   seg_q    <= byte_seg;
                    PK_LOCK:  lock_q   <= 1'b1;
                    PK_REP:   begin rep_q <= 1'b1; repne_q <= 1'b0; end
                    PK_REPNE: begin rep_q <= 1'b0; repne_q <= 1'b1; end
                    default: ;
                endcase
            end else if (is_ext) begin
                ext_q      <= 1'b1;
                ext_bits_q <= byte_i[3:0];
            end else begin
                esc_q <= 1'b1;
            end
        end
    end

    // Record register: loaded with the resolved attributes on the opcode byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            opcode_o     <= 8'h00;
            two_byte_o   <= 1'b0;
            op_bytes_o   <= '0;
            addr_bytes_o <= '0;
            seg_o        <= 3'd0;
            lock_o       <= 1'b0;
            rep_o        <= 1'b0;
            repne_o      <= 1'b0;
            rex_o        <= 1'b0;
            {rex_w_o, rex_r_o, rex_x_o, rex_b_o} <= 4'h0;
        end else begin
            done_o <= finish;
            if (finish) begin
                opcode_o     <= byte_i;
                two_byte_o   <= esc_q;
                op_bytes_o   <= op_sz;
                addr_bytes_o <= ad_sz;
                seg_o        <= seg_q;
                lock_o       <= lock_q;
                rep_o        <= rep_q;
                repne_o      <= repne_q;
                rex_o        <= ext_q;
                {rex_w_o, rex_r_o, rex_x_o, rex_b_o} <= ext_bits_q;
            end
        end
    end

endmodule

// File: rtl/insn_prefix_decoder_chk.sv
// Module: insn_prefix_decoder_chk
// Port-level properties of the prefix decoder, bound onto the top module.
// Assumes: same port names as the top so that the bind can use .*.
module insn_prefix_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       byte_valid_i,
    input logic [7:0] byte_i,
    input logic       byte_ready_o,
    input logic       done_o,
    input logic [7:0] opcode_o,
    input logic       two_byte_o,
    input logic [3:0] op_bytes_o,
    input logic [3:0] addr_bytes_o,
    input logic [2:0] seg_o,
    input logic       lock_o,
    input logic       rep_o,
    input logic       repne_o,
    input logic       rex_o,
    input logic       rex_w_o,
    input logic       rex_r_o,
    input logic       rex_x_o,
    input logic       rex_b_o
);

    // Done never lasts two cycles.
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Record only changes together with a done pulse.
    p_record_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({opcode_o, two_byte_o, op_bytes_o, addr_bytes_o, seg_o,
                             lock_o, rep_o, repne_o, rex_o, rex_w_o, rex_r_o,
                             rex_x_o, rex_b_o}));

    // Ready comes back in the cycle after a done pulse.
    p_ready_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> byte_ready_o);

    // Reported sizes are always legal byte counts.
    p_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((op_bytes_o == 4'd2 || op_bytes_o == 4'd4 || op_bytes_o == 4'd8) &&
                    (addr_bytes_o == 4'd2 || addr_bytes_o == 4'd4 || addr_bytes_o == 4'd8)));

    // Address size pair in 64-bit mode.
    p_addr_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_i == 2'd3) |-> (addr_bytes_o == 4'd4 || addr_bytes_o == 4'd8));

    // Segment code within range.
    p_seg_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seg_o <= 3'd6);

    // Repeat attributes exclusive.
    p_rep_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rep_o && repne_o));

    // W forces 8-byte operands; extension only in 64-bit mode.
    p_ext_w_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rex_o && rex_w_o) |-> (op_bytes_o == 4'd8));

    p_ext_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rex_o) |-> (mode_i == 2'd3));

    // Extension bits never reported without the extension flag.
    p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rex_o |-> !(rex_w_o || rex_r_o || rex_x_o || rex_b_o));

endmodule

bind insn_prefix_decoder insn_prefix_decoder_chk u_chk (.*);

// File: tb/test_insn_prefix_decoder.sv
module test_insn_prefix_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_ready_o, done_o, two_byte_o, lock_o, rep_o, repne_o;
    logic       rex_o, rex_w_o, rex_r_o, rex_x_o, rex_b_o;
    logic [7:0] opcode_o;
    logic [3:0] op_bytes_o, addr_bytes_o;
    logic [2:0] seg_o;

    always #5 clk = ~clk;

    insn_prefix_decoder i_insn_prefix_decoder (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .byte_ready_o(byte_ready_o), .done_o(done_o),
        .opcode_o(opcode_o), .two_byte_o(two_byte_o),
        .op_bytes_o(op_bytes_o), .addr_bytes_o(addr_bytes_o),
        .seg_o(seg_o), .lock_o(lock_o), .rep_o(rep_o), .repne_o(repne_o),
        .rex_o(rex_o), .rex_w_o(rex_w_o), .rex_r_o(rex_r_o),
        .rex_x_o(rex_x_o), .rex_b_o(rex_b_o)
    );

    int tests = 0;
    int fails = 0;
    string scen = "R1";

    // Reference model state (behavioural, per instruction).
    int m_cnt, m_optog, m_adtog, m_seg, m_lock, m_rep, m_ext, m_esc;
    // Expected outputs for the next sample.
    int e_done, e_ready, e_op, e_two, e_osz, e_asz, e_seg, e_lock, e_rep, e_repne;
    int e_rex, e_w, e_r, e_x, e_b;
    bit last_accepted;

    task automatic model_clear();
        m_cnt = 0; m_optog = 0; m_adtog = 0; m_seg = 0; m_lock = 0;
        m_rep = 0; m_ext = -1; m_esc = 0;
    endtask

    function automatic int seg_of(int b);
        case (b)
            'h26: return 1; 'h2E: return 2; 'h36: return 3;
            'h3E: return 4; 'h64: return 5; 'h65: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_legacy(int b);
        return (b == 'h66 || b == 'h67 || b == 'hF0 || b == 'hF2 || b == 'hF3 ||
                seg_of(b) != 0);
    endfunction

    task automatic model_finish(int b, int two);
        int md = int'(mode_i);
        int w  = (m_ext >= 0) ? ((m_ext >> 3) & 1) : 0;
        e_done = 1; e_ready = 0; e_op = b; e_two = two;
        if (w == 1) e_osz = 8;
        else begin
            e_osz = (md < 2) ? 2 : 4;
            if (m_optog != 0) e_osz = 6 - e_osz;
        end
        if (md == 3) e_asz = (m_adtog != 0) ? 4 : 8;
        else if (md == 2) e_asz = (m_adtog != 0) ? 2 : 4;
        else e_asz = (m_adtog != 0) ? 4 : 2;
        e_seg = m_seg; e_lock = m_lock;
        e_rep = (m_rep == 1) ? 1 : 0; e_repne = (m_rep == 2) ? 1 : 0;
        e_rex = (m_ext >= 0) ? 1 : 0;
        e_w = w;
        e_r = (m_ext >= 0) ? ((m_ext >> 2) & 1) : 0;
        e_x = (m_ext >= 0) ? ((m_ext >> 1) & 1) : 0;
        e_b = (m_ext >= 0) ? (m_ext & 1) : 0;
        model_clear();
    endtask

    task automatic model_accept(int b);
        e_done = 0; e_ready = 1;
        if (m_esc != 0) model_finish(b, 1);
        else if (is_legacy(b) && m_cnt < 8) begin
            m_cnt++; m_ext = -1;
            if (b == 'h66) m_optog ^= 1;
            else if (b == 'h67) m_adtog ^= 1;
            else if (b == 'hF0) m_lock = 1;
            else if (b == 'hF3) m_rep = 1;
            else if (b == 'hF2) m_rep = 2;
            else m_seg = seg_of(b);
        end else if (int'(mode_i) == 3 && (b >> 4) == 4) m_ext = b;
        else if (b == 'h0F) m_esc = 1;
        else model_finish(b, 0);
    endtask

    task automatic chk(string req, string name, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", req, scen, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2", "done", int'(done_o), e_done);
        chk("R3", "ready", int'(byte_ready_o), e_ready);
        chk("R10", "opcode", int'(opcode_o), e_op);
        chk("R10", "two_byte", int'(two_byte_o), e_two);
        chk("R4", "op_bytes", int'(op_bytes_o), e_osz);
        chk("R5", "addr_bytes", int'(addr_bytes_o), e_asz);
        chk("R6", "seg", int'(seg_o), e_seg);
        chk("R7", "lock", int'(lock_o), e_lock);
        chk("R7", "rep", int'(rep_o), e_rep);
        chk("R7", "repne", int'(repne_o), e_repne);
        chk("R8", "rex", int'(rex_o), e_rex);
        chk("R8", "rex_w", int'(rex_w_o), e_w);
        chk("R9", "rex_r", int'(rex_r_o), e_r);
        chk("R9", "rex_x", int'(rex_x_o), e_x);
        chk("R9", "rex_b", int'(rex_b_o), e_b);
    endtask

    // One clock: compare at the falling edge, then drive the next beat.
    task automatic tick(bit v, int b);
        @(negedge clk);
        compare();
        byte_valid_i = v;
        byte_i = 8'(b);
        last_accepted = v && (e_ready == 1);
        if (last_accepted) model_accept(b);
        else begin e_done = 0; e_ready = 1; end
    endtask

    task automatic send(int b);
        do tick(1'b1, b); while (!last_accepted);
    endtask

    task automatic idle();
        tick(1'b0, 0);
    endtask

    task automatic set_mode(int md);
        idle(); idle();
        mode_i = 2'(md);
    endtask

    // Watchdog.
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        e_done = 0; e_ready = 1; e_op = 0; e_two = 0; e_osz = 0; e_asz = 0;
        e_seg = 0; e_lock = 0; e_rep = 0; e_repne = 0;
        e_rex = 0; e_w = 0; e_r = 0; e_x = 0; e_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        scen = "R1";
        idle(); idle();

        scen = "R4";
        set_mode(2); send('h89); idle();
        set_mode(0); send('h8B); idle();
        set_mode(1); send('h01); idle();
        set_mode(3); send('h01); idle();

        scen = "R5";
        set_mode(0); send('h66); send('h67); send('h89); idle();
        set_mode(2); send('h66); send('h67); send('h89); idle();
        set_mode(3); send('h67); send('h66); send('h89); idle();
        send('h66); send('h66); send('h67); send('h67); send('h03); idle();

        scen = "R6";
        send('h2E); send('h65); send('h8A); idle();
        send('h26); send('h88);
        send('h36); send('h3E); send('h88);
        send('h64); send('h88); idle();

        scen = "R7";
        send('hF0); send('hF3); send('hF2); send('hA5);
        send('hF2); send('hF3); send('hAB); idle();

        scen = "R3";
        send('h90);
        tick(1'b1, 'h91);   // offered during done cycle: must not be consumed
        tick(1'b1, 'h92);
        idle();

        scen = "R8";
        send('h48); send('h89); idle();
        send('h66); send('h4F); send('h89); idle();
        send('h41); send('h46); send('h0F); send('hB6); idle();
        set_mode(2); send('h48); idle(); set_mode(1); send('h4A); idle();

        scen = "R9";
        set_mode(3); send('h4F); send('h66); send('h01); idle();
        send('h45); send('h2E); send('h44); send('h8B); idle();

        scen = "R10";
        send('h0F); send('hB7); idle();
        send('h0F); send('h66); idle();
        send('h66); send('h0F); send('h0F); idle();

        scen = "R11";
        for (int i = 0; i < 9; i++) send('h66);
        idle();
        for (int i = 0; i < 8; i++) send('h2E);
        send('h3E); idle();
        for (int i = 0; i < 8; i++) send('h67);
        send('h4C); send('hF0); idle();
        set_mode(0);
        for (int i = 0; i < 7; i++) send('h26);
        send('hF0); send('hF3); idle();

        scen = "R2";
        send('h00); send('h66); idle(); idle(); idle();

        idle();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule